// File: doc/BRIEF.md
# Row/Column Strobed Dynamic Memory Array

A synthesizable model of a 4096-cell, one-bit-wide dynamic memory whose cell address arrives in two halves over one 6-bit bus. A falling row strobe captures the row half and copies that whole 64-bit row of the storage array into a row latch. A falling column strobe then captures the column half. The access uses the latch: a read drives the selected bit to the output, and a write replaces it. When the row strobe rises, the latch is written back into the array row.

All strobes are active low. They are sampled on the rising edge of one system clock and compared with their values from the previous edge to find falling and rising transitions. Two refresh styles are supported. A row-only cycle refreshes the row given on the bus. A cycle in which the column strobe falls before the row strobe refreshes the row named by an internal pointer. Within one open row, up to three further column strobe pulses step through the next bits of an aligned group of four columns.

Top module: `dram_mux_array`

## Requirements
- R1: A read returns the bit stored at the row taken from the bus on the row-strobe fall, and at the column taken from the bus on the first column-strobe fall of that row cycle.
- R2: A write into the open row is visible to later reads in the same row cycle. The write reaches the array when the row strobe rises, and other rows are left unchanged.
- R3: On a read, the output-enable flag is 1 from the cycle after the column strobe is sampled low. It is 0 from the cycle after the column strobe is sampled high. Whenever the flag is 0, the data output is 0.
- R4: If the write enable is low at the column-strobe fall, the selected latch bit takes the data input, and the output-enable flag stays 0.
- R5: A row cycle with no column strobe produces no output and leaves the contents of the addressed row unchanged.
- R6: If the column strobe is already low when the row strobe falls, the cycle refreshes the row named by the internal pointer and produces no output. The pointer advances by one after the writeback.
- R7: Within one open row, the 2nd, 3rd and 4th column-strobe pulses access columns whose low two bits count up by one and wrap, for example 6, 7, 4, 5. The upper four column bits are kept. A 5th or later pulse reads nothing and writes nothing.
- R8: The refresh pointer is 0 after reset, changes only at the end of a pointer-refresh cycle, and wraps from 63 to 0.
- R9: The output-enable flag is 0 after reset, and it is 0 in every cycle after one in which the row strobe was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_mux | input | 6 | Multiplexed address: row half, then column half |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| wr_n | input | 1 | Active-low write enable, sampled at the column-strobe fall |
| d_in | input | 1 | Write data |
| d_out | output | 1 | Read data, 0 when not enabled |
| d_out_en | output | 1 | Output-enable flag |

## Verification
Some properties are checked on every cycle. The output-enable flag must be off after either strobe is sampled high. A pointer-refresh cycle must stay silent. The refresh pointer must advance by exactly one at each pointer-refresh writeback and hold at every other time.

Other behaviour can only be shown by the bench scenarios, which compare against a reference copy of the array. These cover data integrity across writebacks and both refresh styles, the column order and cut-off of a nibble burst, and a fifth-pulse write that must be discarded.

// File: rtl/dram_mux_array.sv
module dram_mux_array #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_mux,
  input  logic          row_stb_n,
  input  logic          col_stb_n,
  input  logic          wr_n,
  input  logic          d_in,
  output logic          d_out,
  output logic          d_out_en
);
  localparam int NR = 1 << AW;
  localparam int NC = 1 << AW;

  logic [NC-1:0] cells [NR];
  logic [NC-1:0] rlat;
  logic [AW-1:0] row_sel, col_sel, rfsh_ptr;
  logic          ras_q, cas_q, row_open, is_cbr;
  logic [2:0]    acc_cnt;

  wire ras_fall = ras_q & ~row_stb_n;
  wire ras_rise = ~ras_q & row_stb_n;
  wire cas_fall = cas_q & ~col_stb_n;
  wire col_go   = cas_fall & row_open & ~is_cbr & ~ras_rise & (acc_cnt < 3'd4);
  wire [AW-1:0] next_col = (acc_cnt == 3'd0) ? a_mux : {col_sel[AW-1:2], col_sel[1:0] + 2'd1};
  wire [AW-1:0] open_row = col_stb_n ? a_mux : rfsh_ptr;

  always_ff @(posedge clk)
    if (ras_rise && row_open) cells[row_sel] <= rlat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q    <= 1'b1;
      cas_q    <= 1'b1;
      row_open <= 1'b0;
      is_cbr   <= 1'b0;
      acc_cnt  <= 3'd0;
      row_sel  <= '0;
      col_sel  <= '0;
      rfsh_ptr <= '0;
      rlat     <= '0;
      d_out_en <= 1'b0;
    end else begin
      ras_q <= row_stb_n;
      cas_q <= col_stb_n;
      if (ras_fall) begin
        row_open <= 1'b1;
        acc_cnt  <= 3'd0;
        is_cbr   <= ~col_stb_n;
        row_sel  <= open_row;
        rlat     <= cells[open_row];
      end else if (ras_rise) begin
        row_open <= 1'b0;
        if (row_open && is_cbr) rfsh_ptr <= rfsh_ptr + 1'b1;
      end else if (col_go) begin
        col_sel <= next_col;
        acc_cnt <= acc_cnt + 3'd1;
        if (!wr_n) rlat[next_col] <= d_in;
      end
      if (row_stb_n || col_stb_n) d_out_en <= 1'b0;
      else if (col_go && wr_n)    d_out_en <= 1'b1;
    end
  end

  assign d_out = d_out_en & rlat[col_sel];
endmodule

// File: rtl/dram_mux_array_chk.sv
module dram_mux_array_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          row_stb_n,
  input logic          col_stb_n,
  input logic          d_out_en,
  input logic          row_open,
  input logic          is_cbr,
  input logic          ras_q,
  input logic [AW-1:0] rfsh_ptr
);
  wire ptr_end = row_open && is_cbr && row_stb_n && !ras_q;

  AST_OE_ROW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) row_stb_n |=> !d_out_en); // R9
  AST_OE_COL_IDLE: assert property (@(posedge clk) disable iff (!rst_n) col_stb_n |=> !d_out_en); // R3
  AST_CBR_SILENT:  assert property (@(posedge clk) disable iff (!rst_n) (row_open && is_cbr) |-> !d_out_en); // R6
  AST_PTR_STEP:    assert property (@(posedge clk) disable iff (!rst_n) ptr_end |=> (rfsh_ptr == AW'($past(rfsh_ptr) + 1'b1))); // R6
  AST_PTR_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !ptr_end |=> $stable(rfsh_ptr)); // R8
endmodule

bind dram_mux_array dram_mux_array_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .d_out_en(d_out_en), .row_open(row_open), .is_cbr(is_cbr), .ras_q(ras_q),
  .rfsh_ptr(rfsh_ptr)
);

// File: tb/dram_mux_array_test.sv
module dram_mux_array_test;
  logic clk = 0, rst_n = 0;
  logic [5:0] a_mux = 0;
  logic row_stb_n = 1, col_stb_n = 1, wr_n = 1, d_in = 0;
  logic d_out, d_out_en;

  dram_mux_array uut (.clk(clk), .rst_n(rst_n), .a_mux(a_mux), .row_stb_n(row_stb_n),
    .col_stb_n(col_stb_n), .wr_n(wr_n), .d_in(d_in), .d_out(d_out), .d_out_en(d_out_en));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";
  bit exp_q[$];
  bit [63:0] refm [64];
  logic [5:0] b_row, b_col;
  int b_cnt;
  bit oe_prev = 0;

  function automatic bit pat(int r, int c);
    return bit'(((r * 3 + c * 5) >> 1) ^ c ^ (r >> 2));
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (d_out_en && !oe_prev) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected output actual=%b expected=none", cur_req, d_out);
        end else begin
          bit e;
          e = exp_q.pop_front();
          if (d_out !== e) begin
            errors++;
            $display("FAIL %s read data actual=%b expected=%b", cur_req, d_out, e);
          end
        end
      end
      oe_prev = d_out_en;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic open_row(logic [5:0] r);
    a_mux = r; row_stb_n = 0; b_row = r; b_cnt = 0;
    step(); step();
  endtask

  task automatic close_row();
    row_stb_n = 1;
    step();
    check("R9", d_out_en, 1'b0, "enable after row close");
    step();
  endtask

  task automatic pulse(logic [5:0] c, bit w, bit d);
    if (b_cnt == 0) b_col = c;
    else if (b_cnt < 4) b_col = {b_col[5:2], b_col[1:0] + 2'd1};
    if (b_cnt < 4) begin
      if (w) refm[b_row][b_col] = d;
      else exp_q.push_back(refm[b_row][b_col]);
    end
    b_cnt++;
    a_mux = c; wr_n = w ? 1'b0 : 1'b1; d_in = d; col_stb_n = 0;
    step();
    col_stb_n = 1; wr_n = 1;
    step();
    check("R3", d_out_en, 1'b0, "enable after column rise");
    check("R3", d_out, 1'b0, "data while disabled");
  endtask

  task automatic cbr_cycle();
    col_stb_n = 0; step();
    row_stb_n = 0; step(); step();
    check("R6", d_out_en, 1'b0, "enable during pointer refresh");
    row_stb_n = 1; step();
    col_stb_n = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    check("R9", d_out_en, 1'b0, "enable after reset");
    check("R3", d_out, 1'b0, "data after reset");

    cur_req = "R4";
    foreach (refm[r]) refm[r] = '0;
    for (int r = 0; r < 64; r += 9) begin
      open_row(6'(r));
      for (int c = 0; c < 64; c++) pulse(6'(c), 1, pat(r, c));
      close_row();
    end

    cur_req = "R1";
    for (int k = 0; k < 24; k++) begin
      open_row(6'((k * 9) % 63));
      pulse(6'((k * 13 + 5) % 64), 0, 0);
      close_row();
    end

    cur_req = "R2";
    open_row(6'd18);
    pulse(6'd40, 1, ~refm[18][40]);
    pulse(6'd40, 0, 0);
    close_row();
    open_row(6'd27); pulse(6'd40, 0, 0); close_row();
    open_row(6'd18); pulse(6'd40, 0, 0); close_row();

    cur_req = "R5";
    for (int r = 0; r < 64; r += 9) begin
      a_mux = 6'(r); row_stb_n = 0;
      step(); step();
      check("R5", d_out_en, 1'b0, "enable during row-only refresh");
      row_stb_n = 1; step(); step();
    end
    open_row(6'd9); pulse(6'd3, 0, 0); close_row();

    cur_req = "R6";
    for (int k = 0; k < 70; k++) cbr_cycle();
    cur_req = "R8";
    for (int c = 0; c < 64; c += 7) begin
      open_row(6'd45); pulse(6'(c), 0, 0); close_row();
    end

    cur_req = "R7";
    open_row(6'd36);
    for (int k = 0; k < 6; k++) pulse(6'd6, 0, 0);
    close_row();
    open_row(6'd63);
    for (int k = 0; k < 4; k++) pulse(6'd63, 0, 0);
    close_row();
    open_row(6'd54);
    pulse(6'd13, 1, 1'b1); pulse(6'd0, 1, 1'b0); pulse(6'd0, 1, 1'b1); pulse(6'd0, 1, 1'b0);
    pulse(6'd0, 1, ~refm[54][14]);
    close_row();
    open_row(6'd54);
    for (int k = 0; k < 4; k++) pulse(6'd12, 0, 0);
    close_row();

    step(); step();
    check("R1", exp_q.size() == 0, 1'b1, "pending expected reads empty");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule